// File: doc/BRIEF.md
# Video-Priority Shared DRAM Arbiter

This block lets a processor and a display fetch engine share one bank pair of multiplexed-address dynamic RAM. Each access is a fixed run of clock phases. The row half of the address goes out on the shared 8-bit bus and the row strobe falls. The column half follows with the strobe of the addressed bank, plus the write strobe on processor writes. Data is then captured, and all strobes are released for a precharge clock.

The display engine always wins arbitration. While it owns the memory, the address-source select switches to the display address and the enable of the processor data-bus transceiver is negated. The processor bus stays isolated for the whole display cycle. There is no refresh counter: the display engine sweeps through the rows at regular intervals, and each of its reads is a full row-strobe cycle, so the sweep keeps the memory refreshed.

A processor request to a RAM address that arrives while the memory is busy waits with `cpu_ready` low, then runs in the first idle slot. Processor addresses outside the RAM window are ignored and left to an outside decoder.

Top module: `vram_arbiter`

## Requirements
- R1: While reset is asserted and after it is released with no request pending, the RAS, both CAS and WE outputs are high, `cpu_ready` and `vid_ack` are low, `addr_src_vid` is low, `xcvr_oe_n` is low, and both read-data outputs are zero.
- R2: A processor byte address is RAM when bit 17 is 1 (0x20000 to 0x3FFFF). Bit 16 selects the bank, bits 15:8 are the row and bits 7:0 are the column. A request outside the window never drives RAS, CAS or WE low and never raises `cpu_ready`.
- R3: A granted access takes the idle clock in which it is seen, then five clocks. In the first, RAS is high and the row is driven. In the second, RAS is low with the row. In the third and fourth, RAS is low, the column is driven and CAS is low. In the fifth, all strobes are high and the address is zero. The block then spends at least one idle clock before the next grant.
- R4: During the column clocks only `dram_cas_n[b]` is low, where b is the access's bank. For the processor, b is address bit 16.
- R5: `dram_we_n` is low only in the two column clocks of a processor write, and `dram_wdata` carries the write byte there. It stays high for processor reads and all display cycles.
- R6: For a processor read, the byte on `dram_rdata` at the end of the fourth clock appears on `cpu_rdata` from the fifth clock on, and is held until the next processor read.
- R7: If both sides request in the same idle clock, the display fetch is granted first and the processor is served in the following slot.
- R8: In clocks one to four of a display cycle, `addr_src_vid` and `xcvr_oe_n` are high. The address bus carries `vid_row`, then `vid_col`, and CAS fires for bank VID_BANK. `vid_rdata` takes the fetched byte from the fifth clock on.
- R9: A processor RAM request made while an access is running keeps `cpu_ready` low until its own fifth clock. `cpu_rdata` is not changed by display cycles or processor writes.
- R10: No row cycle starts without a request. Each display fetch gives exactly one RAS fall, carrying its row.
- R11: `cpu_ready` and `vid_ack` are one-clock pulses in the fifth clock of the owning access, and they are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 18 | Processor byte address |
| cpu_req | input | 1 | Processor access request, held until `cpu_ready` |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_wdata | input | 8 | Processor write byte |
| cpu_rdata | output | 8 | Last processor read byte |
| cpu_ready | output | 1 | Processor access complete pulse |
| vid_req | input | 1 | Display fetch request, held until `vid_ack` |
| vid_row | input | 8 | Display fetch row |
| vid_col | input | 8 | Display fetch column |
| vid_rdata | output | 8 | Last display fetch byte |
| vid_ack | output | 1 | Display fetch complete pulse |
| dram_addr | output | 8 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 2 | Per-bank column strobes, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_wdata | output | 8 | Write data to memory |
| dram_rdata | input | 8 | Read data from memory |
| addr_src_vid | output | 1 | Address source select, 1 = display address |
| xcvr_oe_n | output | 1 | Processor bus transceiver enable, active low |

## Verification
The bench builds the block with 8-bit rows and columns and two banks, but sets VID_BANK to 1 rather than its default of 0. Display strobes therefore land on the second CAS line, which is the same bank the processor reaches with bit 16 set. A display fetch can then read back a byte the processor just wrote, so the bench can show that the address source and bank decode agree between the two requesters. A behavioural memory on the strobes and a phase-counting model are checked against the block on every clock. The runs cover same-clock conflicts, requests arriving mid-cycle from either side, an out-of-window request held for many clocks, and a row sweep of display fetches.

// File: rtl/vram_arb_pkg.sv
package vram_arb_pkg;

  // Access phases, one clock each.
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ROW  = 3'd1,
    PH_RAS  = 3'd2,
    PH_CAS  = 3'd3,
    PH_DATA = 3'd4,
    PH_PRE  = 3'd5
  } phase_e;

  typedef enum logic {
    OWN_CPU = 1'b0,
    OWN_VID = 1'b1
  } owner_e;

endpackage

// File: rtl/vram_rst_sync.sv
module vram_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/vram_cpu_decode.sv
module vram_cpu_decode #(
  parameter int          CPU_AW  = 18,
  parameter int          ROW_W   = 8,
  parameter int          COL_W   = 8,
  parameter int          BANK_W  = 1,
  parameter int unsigned RAM_TAG = 1
) (
  input  logic [CPU_AW-1:0] addr,
  output logic              ram_hit,
  output logic [BANK_W-1:0] bank,
  output logic [ROW_W-1:0]  row,
  output logic [COL_W-1:0]  col
);

  localparam int TAG_W  = CPU_AW - BANK_W - ROW_W - COL_W;
  localparam int ROW_LO = COL_W;
  localparam int BNK_LO = COL_W + ROW_W;
  localparam logic [TAG_W-1:0] TAG_VAL = TAG_W'(RAM_TAG);

  assign ram_hit = (addr[CPU_AW-1 -: TAG_W] == TAG_VAL);
  assign bank    = addr[BNK_LO +: BANK_W];
  assign row     = addr[ROW_LO +: ROW_W];
  assign col     = addr[COL_W-1:0];

endmodule

// File: rtl/vram_access_seq.sv
module vram_access_seq
  import vram_arb_pkg::*;
#(
  parameter int          ROW_W    = 8,
  parameter int          COL_W    = 8,
  parameter int          BANK_W   = 1,
  parameter int          DATA_W   = 8,
  parameter int unsigned VID_BANK = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vid_req,
  input  logic [ROW_W-1:0]  vid_row,
  input  logic [COL_W-1:0]  vid_col,
  input  logic              cpu_go,
  input  logic              cpu_wr,
  input  logic [BANK_W-1:0] cpu_bank,
  input  logic [ROW_W-1:0]  cpu_row,
  input  logic [COL_W-1:0]  cpu_col,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic [DATA_W-1:0] dram_rdata,
  output phase_e            phase,
  output owner_e            owner,
  output logic [ROW_W-1:0]  row,
  output logic [COL_W-1:0]  col,
  output logic [BANK_W-1:0] bank,
  output logic              wr,
  output logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic [DATA_W-1:0] vid_rdata
);

  localparam logic [BANK_W-1:0] VID_BANK_SEL = BANK_W'(VID_BANK);

  phase_e            phase_q, phase_d;
  owner_e            owner_q, owner_d;
  logic [ROW_W-1:0]  row_q, row_d;
  logic [COL_W-1:0]  col_q, col_d;
  logic [BANK_W-1:0] bank_q, bank_d;
  logic              wr_q, wr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic [DATA_W-1:0] cpu_rd_q, vid_rd_q;
  logic              cpu_cap_en, vid_cap_en;

  // Next-state: grant in idle (display first), then walk the phases.
  always_comb begin
    phase_d = phase_q;
    owner_d = owner_q;
    row_d   = row_q;
    col_d   = col_q;
    bank_d  = bank_q;
    wr_d    = wr_q;
    wdata_d = wdata_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (vid_req) begin
          phase_d = PH_ROW;
          owner_d = OWN_VID;
          row_d   = vid_row;
          col_d   = vid_col;
          bank_d  = VID_BANK_SEL;
          wr_d    = 1'b0;
        end else if (cpu_go) begin
          phase_d = PH_ROW;
          owner_d = OWN_CPU;
          row_d   = cpu_row;
          col_d   = cpu_col;
          bank_d  = cpu_bank;
          wr_d    = cpu_wr;
          wdata_d = cpu_wdata;
        end
      end
      PH_ROW:  phase_d = PH_RAS;
      PH_RAS:  phase_d = PH_CAS;
      PH_CAS:  phase_d = PH_DATA;
      PH_DATA: phase_d = PH_PRE;
      PH_PRE:  phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  assign cpu_cap_en = (phase_q == PH_DATA) && (owner_q == OWN_CPU) && !wr_q;
  assign vid_cap_en = (phase_q == PH_DATA) && (owner_q == OWN_VID);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      owner_q  <= OWN_CPU;
      row_q    <= '0;
      col_q    <= '0;
      bank_q   <= '0;
      wr_q     <= 1'b0;
      wdata_q  <= '0;
      cpu_rd_q <= '0;
      vid_rd_q <= '0;
    end else begin
      phase_q <= phase_d;
      owner_q <= owner_d;
      row_q   <= row_d;
      col_q   <= col_d;
      bank_q  <= bank_d;
      wr_q    <= wr_d;
      wdata_q <= wdata_d;
      if (cpu_cap_en) begin
        cpu_rd_q <= dram_rdata;
      end
      if (vid_cap_en) begin
        vid_rd_q <= dram_rdata;
      end
    end
  end

  assign phase     = phase_q;
  assign owner     = owner_q;
  assign row       = row_q;
  assign col       = col_q;
  assign bank      = bank_q;
  assign wr        = wr_q;
  assign wdata     = wdata_q;
  assign cpu_rdata = cpu_rd_q;
  assign vid_rdata = vid_rd_q;

endmodule

// File: rtl/vram_strobe_gen.sv
module vram_strobe_gen
  import vram_arb_pkg::*;
#(
  parameter int ROW_W     = 8,
  parameter int COL_W     = 8,
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 1,
  parameter int DATA_W    = 8,
  parameter int MUX_W     = 8
) (
  input  phase_e               phase,
  input  owner_e               owner,
  input  logic [ROW_W-1:0]     row,
  input  logic [COL_W-1:0]     col,
  input  logic [BANK_W-1:0]    bank,
  input  logic                 wr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [MUX_W-1:0]     dram_addr,
  output logic                 ras_n,
  output logic [NUM_BANKS-1:0] cas_n,
  output logic                 we_n,
  output logic [DATA_W-1:0]    dram_wdata,
  output logic                 addr_src_vid,
  output logic                 xcvr_oe_n,
  output logic                 cpu_ready,
  output logic                 vid_ack
);

  logic row_phase, ras_phase, col_phase, busy, vid_cyc, cpu_wr_cyc;

  assign row_phase  = (phase == PH_ROW) || (phase == PH_RAS);
  assign col_phase  = (phase == PH_CAS) || (phase == PH_DATA);
  assign ras_phase  = (phase == PH_RAS) || col_phase;
  assign busy       = row_phase || col_phase;
  assign vid_cyc    = busy && (owner == OWN_VID);
  assign cpu_wr_cyc = col_phase && (owner == OWN_CPU) && wr;

  always_comb begin
    dram_addr = '0;
    if (row_phase) begin
      dram_addr = MUX_W'(row);
    end else if (col_phase) begin
      dram_addr = MUX_W'(col);
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cas
    assign cas_n[b] = !(col_phase && (bank == BANK_W'(b)));
  end

  assign ras_n        = !ras_phase;
  assign we_n         = !cpu_wr_cyc;
  assign dram_wdata   = cpu_wr_cyc ? wdata : '0;
  assign addr_src_vid = vid_cyc;
  assign xcvr_oe_n    = vid_cyc;
  assign cpu_ready    = (phase == PH_PRE) && (owner == OWN_CPU);
  assign vid_ack      = (phase == PH_PRE) && (owner == OWN_VID);

endmodule

// File: rtl/vram_arbiter.sv
module vram_arbiter
  import vram_arb_pkg::*;
#(
  parameter int          CPU_AW    = 18,
  parameter int          ROW_W     = 8,
  parameter int          COL_W     = 8,
  parameter int          DATA_W    = 8,
  parameter int          NUM_BANKS = 2,
  parameter int unsigned RAM_TAG   = 1,
  parameter int unsigned VID_BANK  = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CPU_AW-1:0]    cpu_addr,
  input  logic                 cpu_req,
  input  logic                 cpu_wr,
  input  logic [DATA_W-1:0]    cpu_wdata,
  output logic [DATA_W-1:0]    cpu_rdata,
  output logic                 cpu_ready,
  input  logic                 vid_req,
  input  logic [ROW_W-1:0]     vid_row,
  input  logic [COL_W-1:0]     vid_col,
  output logic [DATA_W-1:0]    vid_rdata,
  output logic                 vid_ack,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
  output logic                 dram_ras_n,
  output logic [NUM_BANKS-1:0] dram_cas_n,
  output logic                 dram_we_n,
  output logic [DATA_W-1:0]    dram_wdata,
  input  logic [DATA_W-1:0]    dram_rdata,
  output logic                 addr_src_vid,
  output logic                 xcvr_oe_n
);

  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int MUX_W  = (ROW_W > COL_W) ? ROW_W : COL_W;

  logic              rst_n_sync;
  logic              ram_hit, cpu_go;
  logic [BANK_W-1:0] dec_bank, seq_bank;
  logic [ROW_W-1:0]  dec_row, seq_row;
  logic [COL_W-1:0]  dec_col, seq_col;
  logic              seq_wr;
  logic [DATA_W-1:0] seq_wdata;
  phase_e            seq_phase;
  owner_e            seq_owner;

  vram_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_sync)
  );

  vram_cpu_decode #(
    .CPU_AW (CPU_AW), .ROW_W (ROW_W), .COL_W (COL_W),
    .BANK_W (BANK_W), .RAM_TAG (RAM_TAG)
  ) u_dec (
    .addr    (cpu_addr),
    .ram_hit (ram_hit),
    .bank    (dec_bank),
    .row     (dec_row),
    .col     (dec_col)
  );

  assign cpu_go = cpu_req && ram_hit;

  vram_access_seq #(
    .ROW_W (ROW_W), .COL_W (COL_W), .BANK_W (BANK_W),
    .DATA_W (DATA_W), .VID_BANK (VID_BANK)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .vid_req    (vid_req),
    .vid_row    (vid_row),
    .vid_col    (vid_col),
    .cpu_go     (cpu_go),
    .cpu_wr     (cpu_wr),
    .cpu_bank   (dec_bank),
    .cpu_row    (dec_row),
    .cpu_col    (dec_col),
    .cpu_wdata  (cpu_wdata),
    .dram_rdata (dram_rdata),
    .phase      (seq_phase),
    .owner      (seq_owner),
    .row        (seq_row),
    .col        (seq_col),
    .bank       (seq_bank),
    .wr         (seq_wr),
    .wdata      (seq_wdata),
    .cpu_rdata  (cpu_rdata),
    .vid_rdata  (vid_rdata)
  );

  vram_strobe_gen #(
    .ROW_W (ROW_W), .COL_W (COL_W), .NUM_BANKS (NUM_BANKS),
    .BANK_W (BANK_W), .DATA_W (DATA_W), .MUX_W (MUX_W)
  ) u_strb (
    .phase        (seq_phase),
    .owner        (seq_owner),
    .row          (seq_row),
    .col          (seq_col),
    .bank         (seq_bank),
    .wr           (seq_wr),
    .wdata        (seq_wdata),
    .dram_addr    (dram_addr),
    .ras_n        (dram_ras_n),
    .cas_n        (dram_cas_n),
    .we_n         (dram_we_n),
    .dram_wdata   (dram_wdata),
    .addr_src_vid (addr_src_vid),
    .xcvr_oe_n    (xcvr_oe_n),
    .cpu_ready    (cpu_ready),
    .vid_ack      (vid_ack)
  );

endmodule

// File: rtl/vram_arbiter_chk.sv
module vram_arbiter_chk #(
  parameter int NUM_BANKS = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 dram_ras_n,
  input logic [NUM_BANKS-1:0] dram_cas_n,
  input logic                 dram_we_n,
  input logic                 addr_src_vid,
  input logic                 xcvr_oe_n,
  input logic                 cpu_ready,
  input logic                 vid_ack
);

  AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    (dram_cas_n != '1) |-> !dram_ras_n); // R3

  AST_PRECHARGE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_ras_n) |=> dram_ras_n); // R3

  AST_SINGLE_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~dram_cas_n) <= 1); // R4

  AST_WE_IN_CPU_COL: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_we_n |-> ((dram_cas_n != '1) && !addr_src_vid)); // R5

  AST_VID_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    addr_src_vid |-> xcvr_oe_n); // R8

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready); // R11

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    vid_ack |=> !vid_ack); // R11

  AST_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_ready && vid_ack)); // R11

  AST_DONE_STROBES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready || vid_ack) |-> (dram_ras_n && dram_we_n)); // R3

endmodule

bind vram_arbiter vram_arbiter_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .dram_ras_n   (dram_ras_n),
  .dram_cas_n   (dram_cas_n),
  .dram_we_n    (dram_we_n),
  .addr_src_vid (addr_src_vid),
  .xcvr_oe_n    (xcvr_oe_n),
  .cpu_ready    (cpu_ready),
  .vid_ack      (vid_ack)
);

// File: tb/vram_arbiter_tb_top.sv
`timescale 1ns/1ps
module vram_arbiter_tb_top;

  localparam int VB = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [17:0] cpu_addr = '0;
  logic        cpu_req = 1'b0, cpu_wr = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic        cpu_ready;
  logic        vid_req = 1'b0;
  logic [7:0]  vid_row = '0, vid_col = '0;
  logic [7:0]  vid_rdata;
  logic        vid_ack;
  logic [7:0]  dram_addr;
  logic        dram_ras_n;
  logic [1:0]  dram_cas_n;
  logic        dram_we_n;
  logic [7:0]  dram_wdata;
  logic [7:0]  dram_rdata = '0;
  logic        addr_src_vid, xcvr_oe_n;

  int checks = 0, errors = 0, cyc = 0, ras_falls = 0;
  bit cmp_on = 0;
  time t_cpu, t_vid;

  always #2 clk = ~clk;

  vram_arbiter #(.VID_BANK(VB)) dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_req(cpu_req),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_ready(cpu_ready), .vid_req(vid_req), .vid_row(vid_row),
    .vid_col(vid_col), .vid_rdata(vid_rdata), .vid_ack(vid_ack),
    .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n), .dram_wdata(dram_wdata), .dram_rdata(dram_rdata),
    .addr_src_vid(addr_src_vid), .xcvr_oe_n(xcvr_oe_n)
  );

  function automatic logic [7:0] seed(int k);
    return 8'((k * 37 + 11) ^ (k >> 8));
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  // Behavioural memory driven by the strobes.
  logic [7:0] dmem [int];
  int  dm_row = 0;
  bit  ras_prev = 1;
  bit [1:0] cas_prev = 2'b11;
  always @(negedge clk) begin
    if (!dram_ras_n && ras_prev) begin
      dm_row = dram_addr;
      ras_falls++;
    end
    for (int b = 0; b < 2; b++) begin
      if (!dram_cas_n[b] && cas_prev[b]) begin
        int key;
        key = b * 65536 + dm_row * 256 + int'(dram_addr);
        if (!dram_we_n) dmem[key] = dram_wdata;
        else dram_rdata = dmem.exists(key) ? dmem[key] : seed(key);
      end
    end
    ras_prev = dram_ras_n;
    cas_prev = dram_cas_n;
  end

  // Reference model: phase counter 0 idle, 1..5 access clocks.
  logic [7:0] rmem [int];
  int ph = 0, m_row = 0, m_col = 0, m_bank = 0, m_key = 0;
  bit own_vid = 0, m_wr = 0;
  logic [7:0] m_wd = '0, e_cpu_rd = '0, e_vid_rd = '0;
  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; e_cpu_rd = '0; e_vid_rd = '0;
    end else begin
      case (ph)
        0: begin
          if (vid_req) begin
            ph = 1; own_vid = 1; m_wr = 0; m_row = vid_row; m_col = vid_col; m_bank = VB;
            m_key = m_bank * 65536 + m_row * 256 + m_col;
          end else if (cpu_req && cpu_addr[17]) begin
            ph = 1; own_vid = 0; m_wr = cpu_wr; m_wd = cpu_wdata;
            m_key = int'(cpu_addr) - 32'h20000;
            m_bank = m_key / 65536; m_row = (m_key / 256) % 256; m_col = m_key % 256;
            if (m_wr) rmem[m_key] = m_wd;
          end
        end
        4: begin
          if (own_vid) e_vid_rd = rmem.exists(m_key) ? rmem[m_key] : seed(m_key);
          else if (!m_wr) e_cpu_rd = rmem.exists(m_key) ? rmem[m_key] : seed(m_key);
          ph = 5;
        end
        5: ph = 0;
        default: ph = ph + 1;
      endcase
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      bit colp, busy;
      logic [1:0] e_cas;
      int e_addr;
      colp = (ph == 3 || ph == 4);
      busy = (ph >= 1 && ph <= 4);
      e_cas = 2'b11;
      if (colp) e_cas[m_bank] = 1'b0;
      e_addr = (ph == 1 || ph == 2) ? m_row : (colp ? m_col : 0);
      chk(dram_ras_n == !(ph >= 2 && ph <= 4), "R3 ras_n", dram_ras_n, !(ph >= 2 && ph <= 4));
      chk(dram_cas_n == e_cas, "R4 cas_n", dram_cas_n, e_cas);
      chk(dram_we_n == !(colp && m_wr && !own_vid), "R5 we_n", dram_we_n, !(colp && m_wr));
      if (colp && m_wr && !own_vid) chk(dram_wdata == m_wd, "R5 wdata", dram_wdata, m_wd);
      chk(int'(dram_addr) == e_addr, "R2 addr", dram_addr, e_addr);
      chk(addr_src_vid == (busy && own_vid), "R8 addr_src_vid", addr_src_vid, busy && own_vid);
      chk(xcvr_oe_n == (busy && own_vid), "R8 xcvr_oe_n", xcvr_oe_n, busy && own_vid);
      chk(cpu_ready == (ph == 5 && !own_vid), "R9 cpu_ready", cpu_ready, ph == 5 && !own_vid);
      chk(vid_ack == (ph == 5 && own_vid), "R7 vid_ack", vid_ack, ph == 5 && own_vid);
      chk(cpu_rdata == e_cpu_rd, "R6 cpu_rdata", cpu_rdata, e_cpu_rd);
      chk(vid_rdata == e_vid_rd, "R8 vid_rdata", vid_rdata, e_vid_rd);
      chk(!(cpu_ready && vid_ack), "R11 exclusive", {cpu_ready, vid_ack}, 0);
    end
  end

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      finish_run();
    end
  end

  task automatic cpu_op(input logic [17:0] a, input bit w, input logic [7:0] d,
                        output logic [7:0] rd);
    @(negedge clk);
    cpu_addr = a; cpu_wr = w; cpu_wdata = d; cpu_req = 1'b1;
    do @(negedge clk); while (!cpu_ready);
    t_cpu = $time; rd = cpu_rdata;
    cpu_req = 1'b0;
  endtask

  task automatic vid_op(input logic [7:0] r, input logic [7:0] c, output logic [7:0] rd);
    @(negedge clk);
    vid_row = r; vid_col = c; vid_req = 1'b1;
    do @(negedge clk); while (!vid_ack);
    t_vid = $time; rd = vid_rdata;
    vid_req = 1'b0;
  endtask

  initial begin
    logic [7:0] rd, rv, keep;
    int falls0, rdy_seen;
    // R1: reset state
    #1;
    chk(dram_ras_n && dram_we_n && dram_cas_n == 2'b11, "R1 strobes", {dram_ras_n, dram_cas_n, dram_we_n}, 4'hF);
    chk(!cpu_ready && !vid_ack && !addr_src_vid && !xcvr_oe_n, "R1 control", {cpu_ready, vid_ack, addr_src_vid, xcvr_oe_n}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cpu_rdata == 0 && vid_rdata == 0, "R1 rdata", {cpu_rdata, vid_rdata}, 0);
    cmp_on = 1;

    // R5/R6: write then read in both banks
    cpu_op(18'h21234, 1, 8'hA5, rd);
    cpu_op(18'h3ABCD, 1, 8'h5C, rd);
    cpu_op(18'h21234, 0, 8'h00, rd);
    chk(rd == 8'hA5, "R6 read bank0", rd, 8'hA5);
    cpu_op(18'h3ABCD, 0, 8'h00, rd);
    chk(rd == 8'h5C, "R6 read bank1", rd, 8'h5C);
    keep = rd;

    // R8: display fetch reads a processor-written byte in VID_BANK
    vid_op(8'hAB, 8'hCD, rv);
    chk(rv == 8'h5C, "R8 vid fetch data", rv, 8'h5C);
    chk(cpu_rdata == keep, "R9 cpu_rdata held", cpu_rdata, keep);

    // R7: same-clock conflict, display first
    fork
      cpu_op(18'h20010, 0, 8'h00, rd);
      vid_op(8'h03, 8'h04, rv);
    join
    chk(t_vid < t_cpu, "R7 video first", int'(t_vid), int'(t_cpu));

    // R9: processor arrives during a display cycle
    fork
      vid_op(8'h10, 8'h20, rv);
      begin repeat (2) @(negedge clk); cpu_op(18'h2FF00, 1, 8'h77, rd); end
    join
    chk(t_cpu > t_vid, "R9 cpu waits", int'(t_cpu), int'(t_vid));

    // display arrives during a processor cycle
    fork
      cpu_op(18'h30101, 0, 8'h00, rd);
      begin repeat (2) @(negedge clk); vid_op(8'h01, 8'h01, rv); end
    join
    chk(t_vid > t_cpu, "R7 no preempt mid-cycle", int'(t_vid), int'(t_cpu));

    // R2: out-of-window request ignored
    falls0 = ras_falls; rdy_seen = 0;
    @(negedge clk);
    cpu_addr = 18'h0BEEF; cpu_wr = 1'b1; cpu_req = 1'b1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (cpu_ready || !dram_we_n || !dram_ras_n) rdy_seen++;
    end
    cpu_req = 1'b0;
    chk(rdy_seen == 0 && ras_falls == falls0, "R2 out of window", rdy_seen, 0);

    // R10: idle produces no row cycles; each fetch is one row cycle
    falls0 = ras_falls;
    repeat (40) @(negedge clk);
    chk(ras_falls == falls0, "R10 no idle refresh", ras_falls, falls0);
    for (int r = 0; r < 256; r += 17) vid_op(8'(r), 8'(255 - r), rv);
    chk(ras_falls == falls0 + 16, "R10 one RAS per fetch", ras_falls, falls0 + 16);
    chk(dm_row == 255, "R10 last row swept", dm_row, 255);

    // R11: pulses
    cpu_op(18'h20000, 0, 8'h00, rd);
    @(negedge clk);
    chk(!cpu_ready, "R11 ready one clock", cpu_ready, 0);

    repeat (4) @(negedge clk);
    cmp_on = 0;
    finish_run();
  end

endmodule